// File: doc/BRIEF.md
# Two-Dimensional Tile Copy Address Generator

This block expands one tile-copy command into every memory address needed to move a rectangular tile of a two-dimensional tensor into a local buffer. A descriptor, loaded once, holds the tensor's layout: the byte address of element (0,0), the number of elements along each dimension, the byte distance between consecutive rows, the element size, and the tile box size. After that, a requester only supplies a tile origin (y, x), a destination buffer address and a barrier slot number.

The block walks the box with rows outermost and columns innermost, one element per clock. For each in-bounds element it raises a source read strobe and address. For every element, in bounds or not, it raises a local-buffer write strobe and address. Elements outside the tensor are never read; the write carries a zero-fill flag instead. Once the last element has been issued, the block reports the barrier slot together with the byte count written for the tile. A new command is accepted only after that report.

Top module: `tile_copy_agu`

## Requirements
- R1: After reset, req_ready_o is 1 and rd_valid_o, wr_valid_o, wr_zero_o and done_valid_o are 0.
- R2: Pulsing desc_load_i while the block is idle (req_ready_o=1) stores all descriptor fields for later commands. A pulse while busy is ignored and leaves the tile in flight and later tiles unchanged.
- R3: A command is accepted on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the next cycle until the cycle after the done_valid_o pulse.
- R4: Starting the cycle after acceptance, wr_valid_o is high for exactly (box_h_m1+1)*(box_w_m1+1) consecutive cycles. The elements are visited with the row index r outer and the column index c inner.
- R5: For element (r,c), rd_addr_o = base + (y0+r)*stride_y + (x0+c)*elem_bytes, taken modulo 2^AW.
- R6: The k-th write of a tile (k from 0) has wr_addr_o = dst + k*elem_bytes.
- R7: An element is out of bounds when y0+r >= ext_y or x0+c >= ext_x. Such an element has rd_valid_o=0 and wr_zero_o=1. An in-bounds element has rd_valid_o=1 and wr_zero_o=0.
- R8: done_valid_o pulses for one cycle, in the cycle right after the last write. In that cycle done_bar_o equals the command's barrier slot and done_bytes_o equals (box_h_m1+1)*(box_w_m1+1)*elem_bytes, with zero-filled elements included.
- R9: The element size field desc_esz_i encodes elem_bytes = 1 << desc_esz_i, giving 1, 2, 4 or 8 bytes.
- R10: req_valid_i and the command fields are ignored while req_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_load_i | input | 1 | Store descriptor fields (idle only) |
| desc_base_i | input | AW | Byte address of element (0,0) |
| desc_ext_y_i | input | CW | Tensor extent in rows |
| desc_ext_x_i | input | CW | Tensor extent in columns |
| desc_stride_y_i | input | AW | Byte distance between rows |
| desc_box_h_m1_i | input | BW | Box height minus one |
| desc_box_w_m1_i | input | BW | Box width minus one |
| desc_esz_i | input | 2 | log2 of element bytes |
| req_valid_i | input | 1 | Command present |
| req_ready_o | output | 1 | Block idle, command can be taken |
| req_y_i | input | CW | Tile origin row |
| req_x_i | input | CW | Tile origin column |
| req_dst_i | input | AW | Destination buffer byte address |
| req_bar_i | input | BARW | Barrier slot to signal |
| rd_valid_o | output | 1 | Source read request |
| rd_addr_o | output | AW | Source byte address |
| wr_valid_o | output | 1 | Local-buffer write request |
| wr_addr_o | output | AW | Local-buffer byte address |
| wr_zero_o | output | 1 | Write zeros (out-of-bounds element) |
| done_valid_o | output | 1 | Tile completion pulse |
| done_bar_o | output | BARW | Barrier slot being signalled |
| done_bytes_o | output | 2*BW+4 | Bytes delivered by the tile |

## Verification
The bench builds the block with AW=32, CW=12, BW=4 and BARW=3. The 4-bit box fields allow tiles up to 16x16, so a full-size box with 8-byte elements (2048 bytes) runs in a few hundred cycles and fills the byte counter to its top bit. The small coordinate width keeps the tensor extents small enough that a tile can straddle the bottom and right edges, or lie entirely outside the tensor, with origins the bench writes out directly. Every element size and a non-contiguous row stride are covered, as are back-to-back commands held on req_valid_i, descriptor loads attempted mid-tile, and command changes attempted while the block is busy.

// File: rtl/tile_agu_pkg.sv
package tile_agu_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE,
    WALK_RUN,
    WALK_REPORT
  } walk_state_e;

  function automatic logic [3:0] esz_bytes(input logic [1:0] esz);
    return 4'(1) << esz;
  endfunction

endpackage

// File: rtl/tile_walk_ctr.sv
module tile_walk_ctr
  import tile_agu_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [BW-1:0] box_h_m1_i,
  input  logic [BW-1:0] box_w_m1_i,
  output logic          idle_o,
  output logic          active_o,
  output logic          report_o,
  output logic          row_wrap_o,
  output logic [BW-1:0] row_o,
  output logic [BW-1:0] col_o
);

  walk_state_e   state_q;
  logic [BW-1:0] row_q, col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WALK_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        WALK_IDLE: begin
          if (start_i) begin
            state_q <= WALK_RUN;
            row_q   <= '0;
            col_q   <= '0;
          end
        end
        WALK_RUN: begin
          if (col_q == box_w_m1_i) begin
            col_q <= '0;
            if (row_q == box_h_m1_i) state_q <= WALK_REPORT;
            else                     row_q   <= row_q + 1'b1;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        WALK_REPORT: state_q <= WALK_IDLE;
        default:     state_q <= WALK_IDLE;
      endcase
    end
  end

  assign idle_o     = (state_q == WALK_IDLE);
  assign active_o   = (state_q == WALK_RUN);
  assign report_o   = (state_q == WALK_REPORT);
  assign row_wrap_o = active_o && (col_q == box_w_m1_i);
  assign row_o      = row_q;
  assign col_o      = col_q;

endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  input  logic          row_wrap_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_y_i,
  input  logic [CW-1:0] ext_y_i,
  input  logic [CW-1:0] ext_x_i,
  input  logic [1:0]    esz_i,
  input  logic [CW-1:0] y0_i,
  input  logic [CW-1:0] x0_i,
  input  logic [AW-1:0] dst_i,
  input  logic [BW-1:0] row_i,
  input  logic [BW-1:0] col_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          oob_o
);

  localparam int SW = CW + 2;

  logic [CW-1:0] y0_q, x0_q;
  logic [AW-1:0] row_addr_q, dst_q;
  logic [SW-1:0] yc, xc;
  logic [AW-1:0] eb;

  assign eb = AW'(1) << esz_i;
  assign yc = SW'(y0_q) + SW'(row_i);
  assign xc = SW'(x0_q) + SW'(col_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y0_q       <= '0;
      x0_q       <= '0;
      row_addr_q <= '0;
      dst_q      <= '0;
    end else if (start_i) begin
      y0_q       <= y0_i;
      x0_q       <= x0_i;
      row_addr_q <= base_i + AW'(y0_i) * stride_y_i;
      dst_q      <= dst_i;
    end else if (step_i) begin
      dst_q <= dst_q + eb;
      if (row_wrap_i) row_addr_q <= row_addr_q + stride_y_i;
    end
  end

  assign rd_addr_o = row_addr_q + (AW'(xc) << esz_i);
  assign wr_addr_o = dst_q;
  assign oob_o     = (yc >= SW'(ext_y_i)) || (xc >= SW'(ext_x_i));

endmodule

// File: rtl/tile_byte_acct.sv
module tile_byte_acct
  import tile_agu_pkg::*;
#(
  parameter int BARW = 4,
  parameter int BYW  = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            step_i,
  input  logic [1:0]      esz_i,
  input  logic [BARW-1:0] bar_i,
  output logic [BARW-1:0] bar_o,
  output logic [BYW-1:0]  bytes_o
);

  logic [BARW-1:0] bar_q;
  logic [BYW-1:0]  bytes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_q   <= '0;
      bytes_q <= '0;
    end else if (start_i) begin
      bar_q   <= bar_i;
      bytes_q <= '0;
    end else if (step_i) begin
      bytes_q <= bytes_q + BYW'(esz_bytes(esz_i));
    end
  end

  assign bar_o   = bar_q;
  assign bytes_o = bytes_q;

endmodule

// File: rtl/tile_copy_agu.sv
module tile_copy_agu #(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int BW   = 8,
  parameter int BARW = 4,
  localparam int BYW = 2 * BW + 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            desc_load_i,
  input  logic [AW-1:0]   desc_base_i,
  input  logic [CW-1:0]   desc_ext_y_i,
  input  logic [CW-1:0]   desc_ext_x_i,
  input  logic [AW-1:0]   desc_stride_y_i,
  input  logic [BW-1:0]   desc_box_h_m1_i,
  input  logic [BW-1:0]   desc_box_w_m1_i,
  input  logic [1:0]      desc_esz_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [CW-1:0]   req_y_i,
  input  logic [CW-1:0]   req_x_i,
  input  logic [AW-1:0]   req_dst_i,
  input  logic [BARW-1:0] req_bar_i,
  output logic            rd_valid_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic            wr_valid_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic            wr_zero_o,
  output logic            done_valid_o,
  output logic [BARW-1:0] done_bar_o,
  output logic [BYW-1:0]  done_bytes_o
);

  logic [AW-1:0] base_q, stride_q;
  logic [CW-1:0] ext_y_q, ext_x_q;
  logic [BW-1:0] box_h_q, box_w_q;
  logic [1:0]    desc_esz_q;

  logic          idle, active, report, row_wrap, oob, start;
  logic [BW-1:0] row, col;

  assign start = req_valid_i && idle;

  // descriptor frozen while a tile is in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q     <= '0;
      stride_q   <= '0;
      ext_y_q    <= '0;
      ext_x_q    <= '0;
      box_h_q    <= '0;
      box_w_q    <= '0;
      desc_esz_q <= '0;
    end else if (desc_load_i && idle) begin
      base_q     <= desc_base_i;
      stride_q   <= desc_stride_y_i;
      ext_y_q    <= desc_ext_y_i;
      ext_x_q    <= desc_ext_x_i;
      box_h_q    <= desc_box_h_m1_i;
      box_w_q    <= desc_box_w_m1_i;
      desc_esz_q <= desc_esz_i;
    end
  end

  tile_walk_ctr #(.BW(BW)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .box_h_m1_i (box_h_q),
    .box_w_m1_i (box_w_q),
    .idle_o     (idle),
    .active_o   (active),
    .report_o   (report),
    .row_wrap_o (row_wrap),
    .row_o      (row),
    .col_o      (col)
  );

  tile_addr_gen #(.AW(AW), .CW(CW), .BW(BW)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .step_i     (active),
    .row_wrap_i (row_wrap),
    .base_i     (base_q),
    .stride_y_i (stride_q),
    .ext_y_i    (ext_y_q),
    .ext_x_i    (ext_x_q),
    .esz_i      (desc_esz_q),
    .y0_i       (req_y_i),
    .x0_i       (req_x_i),
    .dst_i      (req_dst_i),
    .row_i      (row),
    .col_i      (col),
    .rd_addr_o  (rd_addr_o),
    .wr_addr_o  (wr_addr_o),
    .oob_o      (oob)
  );

  tile_byte_acct #(.BARW(BARW), .BYW(BYW)) u_acct (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .step_i  (active),
    .esz_i   (desc_esz_q),
    .bar_i   (req_bar_i),
    .bar_o   (done_bar_o),
    .bytes_o (done_bytes_o)
  );

  assign req_ready_o  = idle;
  assign rd_valid_o   = active && !oob;
  assign wr_valid_o   = active;
  assign wr_zero_o    = active && oob;
  assign done_valid_o = report;

endmodule

// File: rtl/tile_copy_agu_chk.sv
module tile_copy_agu_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          rd_valid_o,
  input logic          wr_valid_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          wr_zero_o,
  input logic          done_valid_o,
  input logic [1:0]    desc_esz_q
);

  a_r3_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r3_ready_low_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o || done_valid_o) |-> !req_ready_o);

  a_r7_read_only_in_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (wr_valid_o && !wr_zero_o));

  a_r7_zero_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_zero_o |-> (wr_valid_o && !rd_valid_o));

  a_r8_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |=> (!done_valid_o && req_ready_o));

  a_r8_done_after_last_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> ($past(wr_valid_o) && !wr_valid_o));

  a_r6_dst_linear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && $past(wr_valid_o)) |-> (wr_addr_o == $past(wr_addr_o) + (AW'(1) << desc_esz_q)));

endmodule

bind tile_copy_agu tile_copy_agu_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rd_valid_o   (rd_valid_o),
  .wr_valid_o   (wr_valid_o),
  .wr_addr_o    (wr_addr_o),
  .wr_zero_o    (wr_zero_o),
  .done_valid_o (done_valid_o),
  .desc_esz_q   (desc_esz_q)
);

// File: tb/tile_copy_agu_tb.sv
module tile_copy_agu_tb;

  localparam int AW   = 32;
  localparam int CW   = 12;
  localparam int BW   = 4;
  localparam int BARW = 3;
  localparam int BYW  = 2 * BW + 4;
  localparam longint MASK = 64'hFFFF_FFFF;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            desc_load = 1'b0;
  logic [AW-1:0]   desc_base = '0;
  logic [CW-1:0]   desc_ext_y = '0, desc_ext_x = '0;
  logic [AW-1:0]   desc_stride = '0;
  logic [BW-1:0]   desc_h_m1 = '0, desc_w_m1 = '0;
  logic [1:0]      desc_esz = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [CW-1:0]   req_y = '0, req_x = '0;
  logic [AW-1:0]   req_dst = '0;
  logic [BARW-1:0] req_bar = '0;
  logic            rd_valid, wr_valid, wr_zero, done_valid;
  logic [AW-1:0]   rd_addr, wr_addr;
  logic [BARW-1:0] done_bar;
  logic [BYW-1:0]  done_bytes;

  always #2 clk = ~clk;

  tile_copy_agu #(.AW(AW), .CW(CW), .BW(BW), .BARW(BARW)) u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .desc_load_i     (desc_load),
    .desc_base_i     (desc_base),
    .desc_ext_y_i    (desc_ext_y),
    .desc_ext_x_i    (desc_ext_x),
    .desc_stride_y_i (desc_stride),
    .desc_box_h_m1_i (desc_h_m1),
    .desc_box_w_m1_i (desc_w_m1),
    .desc_esz_i      (desc_esz),
    .req_valid_i     (req_valid),
    .req_ready_o     (req_ready),
    .req_y_i         (req_y),
    .req_x_i         (req_x),
    .req_dst_i       (req_dst),
    .req_bar_i       (req_bar),
    .rd_valid_o      (rd_valid),
    .rd_addr_o       (rd_addr),
    .wr_valid_o      (wr_valid),
    .wr_addr_o       (wr_addr),
    .wr_zero_o       (wr_zero),
    .done_valid_o    (done_valid),
    .done_bar_o      (done_bar),
    .done_bytes_o    (done_bytes)
  );

  typedef struct {
    bit     rdv;
    bit     wrv;
    bit     zero;
    longint rda;
    longint wra;
    bit     done;
    longint bytes;
    longint bar;
  } exp_t;

  exp_t   q[$];
  bit     cur_idle = 1'b1;
  int     n_chk = 0;
  int     n_fail = 0;
  string  ctx = "R1";

  longint m_base = 0, m_stride = 0;
  int     m_ey = 0, m_ex = 0, m_h = 1, m_w = 1, m_esz = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual 0x%0h expected 0x%0h at %0t", req, ctx, what, act, exp, $time);
    end
  endtask

  task automatic enqueue(int y, int x, longint dst, int bar);
    int     k = 0;
    longint eb = longint'(1) << m_esz;
    for (int r = 0; r < m_h; r++) begin
      for (int c = 0; c < m_w; c++) begin
        exp_t e;
        bit   oob = ((y + r) >= m_ey) || ((x + c) >= m_ex);
        e.rdv   = !oob;
        e.wrv   = 1'b1;
        e.zero  = oob;
        e.rda   = (m_base + longint'(y + r) * m_stride + longint'(x + c) * eb) & MASK;
        e.wra   = (dst + longint'(k) * eb) & MASK;
        e.done  = 1'b0;
        e.bytes = 0;
        e.bar   = 0;
        q.push_back(e);
        k++;
      end
    end
    begin
      exp_t d;
      d.rdv = 0; d.wrv = 0; d.zero = 0; d.rda = 0; d.wra = 0;
      d.done  = 1'b1;
      d.bytes = longint'(m_h * m_w) * eb;
      d.bar   = bar;
      q.push_back(d);
    end
  endtask

  task automatic compare();
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      cur_idle = 1'b0;
    end else begin
      e.rdv = 0; e.wrv = 0; e.zero = 0; e.rda = 0; e.wra = 0;
      e.done = 0; e.bytes = 0; e.bar = 0;
      cur_idle = 1'b1;
    end
    chk(req_ready == cur_idle, "R3", "req_ready", longint'(req_ready), longint'(cur_idle));
    chk(wr_valid == e.wrv, "R4", "wr_valid", longint'(wr_valid), longint'(e.wrv));
    chk(rd_valid == e.rdv, "R7", "rd_valid", longint'(rd_valid), longint'(e.rdv));
    chk(wr_zero == e.zero, "R7", "wr_zero", longint'(wr_zero), longint'(e.zero));
    if (e.rdv) chk(longint'(rd_addr) == e.rda, "R5", "rd_addr", longint'(rd_addr), e.rda);
    if (e.wrv) chk(longint'(wr_addr) == e.wra, "R6", "wr_addr", longint'(wr_addr), e.wra);
    chk(done_valid == e.done, "R8", "done_valid", longint'(done_valid), longint'(e.done));
    if (e.done) begin
      chk(longint'(done_bytes) == e.bytes, "R8", "done_bytes", longint'(done_bytes), e.bytes);
      chk(longint'(done_bar) == e.bar, "R8", "done_bar", longint'(done_bar), e.bar);
    end
  endtask

  task automatic step();
    bit acc = req_valid && cur_idle;
    bit ld  = desc_load && cur_idle;
    @(posedge clk);
    if (ld) begin
      m_base = longint'(desc_base); m_stride = longint'(desc_stride);
      m_ey = int'(desc_ext_y); m_ex = int'(desc_ext_x);
      m_h = int'(desc_h_m1) + 1; m_w = int'(desc_w_m1) + 1; m_esz = int'(desc_esz);
    end
    if (acc) enqueue(int'(req_y), int'(req_x), longint'(req_dst), int'(req_bar));
    @(negedge clk);
    compare();
  endtask

  task automatic load_desc(longint base, int ey, int ex, longint stride, int h_m1, int w_m1, int esz);
    desc_base = AW'(base); desc_ext_y = CW'(ey); desc_ext_x = CW'(ex);
    desc_stride = AW'(stride); desc_h_m1 = BW'(h_m1); desc_w_m1 = BW'(w_m1);
    desc_esz = 2'(esz);
    desc_load = 1'b1;
    step();
    desc_load = 1'b0;
  endtask

  task automatic set_req(int y, int x, longint dst, int bar);
    req_y = CW'(y); req_x = CW'(x); req_dst = AW'(dst); req_bar = BARW'(bar);
  endtask

  task automatic run_tile(int y, int x, longint dst, int bar);
    set_req(y, x, dst, bar);
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    while (!cur_idle) step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    ctx = "R1";
    compare();
    rst_n = 1'b1;
    step();

    // R2 R9: 2-byte elements, 3x4 box, in bounds
    ctx = "R2";
    load_desc(64'h1000, 20, 30, 64, 2, 3, 1);
    ctx = "R4";
    run_tile(2, 5, 64'h200, 5);

    // R7: box straddles bottom and right edges
    ctx = "R7";
    run_tile(18, 28, 64'h400, 2);

    // R2: descriptor load mid-tile must be ignored
    ctx = "R2";
    set_req(1, 1, 64'h800, 3);
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    step();
    desc_base = 32'hDEAD_0000; desc_stride = 32'h10; desc_esz = 2'd3;
    desc_h_m1 = 4'd0; desc_w_m1 = 4'd0; desc_ext_x = 12'd1;
    desc_load = 1'b1;
    step();
    desc_load = 1'b0;
    while (!cur_idle) step();
    run_tile(0, 0, 64'h900, 1);

    // R10: command changes while busy are ignored
    ctx = "R10";
    set_req(3, 2, 64'hA00, 6);
    req_valid = 1'b1;
    step();
    for (int i = 0; i < 4; i++) begin
      set_req(7, 7, 64'hBEEF0, 7);
      step();
    end
    req_valid = 1'b0;
    while (!cur_idle) step();

    // R3: valid held high, back-to-back acceptance
    ctx = "R3";
    set_req(4, 4, 64'hC00, 4);
    req_valid = 1'b1;
    step();
    while (!cur_idle) step();
    step();
    req_valid = 1'b0;
    while (!cur_idle) step();

    // R9: 1-byte elements, 1x1 box, odd stride
    ctx = "R9";
    load_desc(64'h3, 5, 9, 7, 0, 0, 0);
    run_tile(4, 8, 64'h11, 0);
    run_tile(5, 8, 64'h12, 1);

    // R9: 4-byte elements, wrapping address
    load_desc(64'hFFFF_FFF0, 8, 8, 32, 1, 2, 2);
    run_tile(1, 3, 64'hFFFF_FFFC, 2);

    // R8: full 16x16 box of 8-byte elements, partly out of bounds
    ctx = "R8";
    load_desc(64'h2_0000, 10, 12, 200, 15, 15, 3);
    run_tile(0, 0, 64'h4000, 7);

    // R7: box entirely outside the tensor
    ctx = "R7";
    load_desc(64'h100, 4, 4, 16, 1, 1, 1);
    run_tile(6, 9, 64'h50, 3);

    repeat (2) step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule